// File: doc/BRIEF.md
# Address-Tagged Serial Write Decoder

This block sits behind a serial slave front end (I2C or SPI) and turns the bytes it receives into write strobes for three on-chip stores: the character-code RAM, the control registers and the downloadable font RAM. The top bits of each byte say whether it carries a high address, a low address or data. The decoder keeps a write pointer, so the host can send an address pair before every data byte, change only the low address between data bytes, or send one address pair and then stream data into consecutive locations.

Each data byte produces at most one registered write: a strobe, a target code, a packed address and the data. The decoder maps the display address space itself. Character codes live in rows 0 to 9, columns 0 to 23. Per-row control registers live in columns 30 and 31 of those rows. Window and frame registers live in row 10, columns 0 to 12. A data byte aimed anywhere else produces no strobe. Transaction start and stop pulses from the front end send the decoder back to waiting for a high address.

Top module: `addr_tag_write_decoder`

## Requirements
- R1: Synchronous active-high reset clears `wr_en` and returns the decoder to waiting for a high-address byte, so a data byte that follows reset with no address writes nothing.
- R2: A data byte accepted on a clock edge produces its write on the outputs from that edge. The strobe is high for exactly one cycle for each data byte.
- R3: A byte with bits 7:6 = 10 is a display high address whose row is bits 3:0. The next byte, with bit 7 = 0 and bit 6 = 0, is a column (bits 4:0). The byte after that is data, written with `wr_addr` = {row, column} (row in bits 8:5, column in bits 4:0).
- R4: After a data byte, a byte with bits 7:6 = 00 replaces only the low address. The next data byte is written to the new column of the same row.
- R5: A low-address byte with bit 6 = 1 that follows a high address enters streaming. Every later byte in the transaction is data, whatever its top bits. After each data byte the column advances, and after column 31 it wraps to column 0 of the next row.
- R6: A byte with bits 7:6 = 11 is a font segment address (bits 3:0). A following line byte (bits 3:0) uses bits 7:6 = 00 for single writes and 01 for streaming. Font writes use `wr_addr` = {segment, line} in bits 7:0 and `wr_data` = the byte's bits 4:0 with bits 7:5 zero. Streaming past line 15 wraps to line 0 of the next segment.
- R7: `wr_tgt` is 0 for character codes (rows 0 to 9, columns 0 to 23) and 1 for control registers (rows 0 to 9, columns 30 and 31; row 10, columns 0 to 12). It is 2 for font RAM. Data aimed at any other display location raises no strobe, but a streaming pointer still advances past it.
- R8: After a data byte, a high-address byte starts a fresh address pair, as in R3.
- R9: After a data byte, a low-address byte with bit 6 = 1 is ignored. The address is unchanged and the next byte is still taken as an address.
- R10: A stop pulse returns the decoder to waiting. A byte presented in the same cycle as a stop is discarded.
- R11: A byte presented in the same cycle as a start pulse is decoded as the first byte of the new transaction.
- R12: While waiting for a high address, a byte with bit 7 = 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | `rx_byte` holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| txn_start | input | 1 | Start of a transaction (one-cycle pulse) |
| txn_stop | input | 1 | End of a transaction (one-cycle pulse) |
| wr_en | output | 1 | Write strobe, one cycle per mapped data byte |
| wr_tgt | output | 2 | Target: 0 character RAM, 1 control registers, 2 font RAM |
| wr_addr | output | 9 | {row, column} for display, {segment, line} for font |
| wr_data | output | 8 | Data to write |

## Verification
Two transaction markers can coincide with a byte strobe, and the bench provokes both. A start arrives on the same cycle as a byte while streaming is under way. The bench expects that byte to be taken as a fresh row address, and expects the following column and data bytes to write at that new location rather than at the advancing stream pointer. A stop arrives on the same cycle as a streaming byte. The bench expects no strobe for that byte and none for the byte after it, because the stream may not continue past the stop.

// File: rtl/atwd_pkg.sv
`timescale 1ns/1ps
package atwd_pkg;

  typedef enum logic [1:0] {
    TGT_CHAR = 2'd0,
    TGT_CTRL = 2'd1,
    TGT_FONT = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HI     = 3'd1,
    ST_LO     = 3'd2,
    ST_AFTER  = 3'd3,
    ST_STREAM = 3'd4
  } st_e;

endpackage

// File: rtl/atwd_tag_classify.sv
`timescale 1ns/1ps
module atwd_tag_classify #(
  parameter int BYTE_W = 8,
  parameter int HI_W   = 4,
  parameter int LO_W   = 5
) (
  input  logic [BYTE_W-1:0] byte_in,
  output logic              is_hi,
  output logic              mode_bit,
  output logic [HI_W-1:0]   hi_val,
  output logic [LO_W-1:0]   lo_val
);
  // Top bit: high (row/segment) address versus low (column/line) address.
  // Next bit: font space for a high byte, streaming request for a low byte.
  always_comb begin
    is_hi    = byte_in[BYTE_W-1];
    mode_bit = byte_in[BYTE_W-2];
    hi_val   = byte_in[HI_W-1:0];
    lo_val   = byte_in[LO_W-1:0];
  end
endmodule

// File: rtl/atwd_pointer.sv
`timescale 1ns/1ps
module atwd_pointer #(
  parameter int HI_W   = 4,
  parameter int LO_W   = 5,
  parameter int LINE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            font,
  input  logic            load_hi,
  input  logic [HI_W-1:0] hi_in,
  input  logic            load_lo,
  input  logic [LO_W-1:0] lo_in,
  input  logic            inc,
  output logic [HI_W-1:0] hi,
  output logic [LO_W-1:0] lo
);
  localparam logic [LO_W-1:0] COL_TOP  = {LO_W{1'b1}};
  localparam logic [LO_W-1:0] LINE_TOP = LO_W'((1 << LINE_W) - 1);

  logic [LO_W-1:0] lo_top;
  logic [LO_W-1:0] lo_masked;

  always_comb begin
    lo_top    = font ? LINE_TOP : COL_TOP;
    lo_masked = font ? (lo_in & LINE_TOP) : lo_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= '0;
      lo <= '0;
    end else begin
      if (load_hi) hi <= hi_in;
      if (load_lo) begin
        lo <= lo_masked;
      end else if (inc) begin
        if (lo == lo_top) begin
          lo <= '0;
          hi <= hi + 1'b1;
        end else begin
          lo <= lo + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/atwd_map_check.sv
`timescale 1ns/1ps
module atwd_map_check
  import atwd_pkg::*;
#(
  parameter int HI_W      = 4,
  parameter int LO_W      = 5,
  parameter int LINE_W    = 4,
  parameter int CHAR_ROWS = 10,
  parameter int CHAR_COLS = 24,
  parameter int RCTL_COL  = 30,
  parameter int CTRL_ROW  = 10,
  parameter int CTRL_COLS = 13,
  localparam int ADDR_W   = HI_W + LO_W
) (
  input  logic              font,
  input  logic [HI_W-1:0]   hi,
  input  logic [LO_W-1:0]   lo,
  output tgt_e              tgt,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [HI_W-1:0] ROWS_LIM  = HI_W'(CHAR_ROWS);
  localparam logic [HI_W-1:0] CROW      = HI_W'(CTRL_ROW);
  localparam logic [LO_W-1:0] COLS_LIM  = LO_W'(CHAR_COLS);
  localparam logic [LO_W-1:0] RCTL_LO   = LO_W'(RCTL_COL);
  localparam logic [LO_W-1:0] CCOLS_LIM = LO_W'(CTRL_COLS);

  always_comb begin
    tgt  = TGT_NONE;
    addr = {hi, lo};
    if (font) begin
      tgt  = TGT_FONT;
      addr = ADDR_W'({hi, lo[LINE_W-1:0]});
    end else if (hi < ROWS_LIM) begin
      if (lo < COLS_LIM)      tgt = TGT_CHAR;
      else if (lo >= RCTL_LO) tgt = TGT_CTRL;
    end else if (hi == CROW && lo < CCOLS_LIM) begin
      tgt = TGT_CTRL;
    end
  end
endmodule

// File: rtl/addr_tag_write_decoder.sv
`timescale 1ns/1ps
module addr_tag_write_decoder
  import atwd_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int HI_W      = 4,
  parameter int LO_W      = 5,
  parameter int LINE_W    = 4,
  parameter int FONT_W    = 5,
  parameter int CHAR_ROWS = 10,
  parameter int CHAR_COLS = 24,
  parameter int RCTL_COL  = 30,
  parameter int CTRL_ROW  = 10,
  parameter int CTRL_COLS = 13,
  localparam int ADDR_W   = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              txn_start,
  input  logic              txn_stop,
  output logic              wr_en,
  output logic [1:0]        wr_tgt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  st_e state, state_eff, state_nxt;
  logic font_q, font_nxt;

  logic            is_hi, mode_bit;
  logic [HI_W-1:0] hi_val, ptr_hi;
  logic [LO_W-1:0] lo_val, ptr_lo;

  logic load_hi, load_lo, do_inc, do_write;
  tgt_e              map_tgt;
  logic [ADDR_W-1:0] map_addr;
  logic [BYTE_W-1:0] data_sel;

  atwd_tag_classify #(.BYTE_W(BYTE_W), .HI_W(HI_W), .LO_W(LO_W)) u_cls (
    .byte_in (rx_byte),
    .is_hi   (is_hi),
    .mode_bit(mode_bit),
    .hi_val  (hi_val),
    .lo_val  (lo_val)
  );

  atwd_pointer #(.HI_W(HI_W), .LO_W(LO_W), .LINE_W(LINE_W)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .font   (font_q),
    .load_hi(load_hi),
    .hi_in  (hi_val),
    .load_lo(load_lo),
    .lo_in  (lo_val),
    .inc    (do_inc),
    .hi     (ptr_hi),
    .lo     (ptr_lo)
  );

  atwd_map_check #(
    .HI_W(HI_W), .LO_W(LO_W), .LINE_W(LINE_W),
    .CHAR_ROWS(CHAR_ROWS), .CHAR_COLS(CHAR_COLS), .RCTL_COL(RCTL_COL),
    .CTRL_ROW(CTRL_ROW), .CTRL_COLS(CTRL_COLS)
  ) u_map (
    .font(font_q),
    .hi  (ptr_hi),
    .lo  (ptr_lo),
    .tgt (map_tgt),
    .addr(map_addr)
  );

  // Decode step: a start restarts decoding with the current byte;
  // a stop discards the current byte.
  always_comb begin
    state_eff = txn_start ? ST_IDLE : state;
    state_nxt = state_eff;
    font_nxt  = font_q;
    load_hi   = 1'b0;
    load_lo   = 1'b0;
    do_inc    = 1'b0;
    do_write  = 1'b0;
    if (txn_stop) begin
      state_nxt = ST_IDLE;
    end else if (byte_valid) begin
      case (state_eff)
        ST_IDLE: begin
          if (is_hi) begin
            load_hi   = 1'b1;
            font_nxt  = mode_bit;
            state_nxt = ST_HI;
          end
        end
        ST_HI: begin
          if (is_hi) begin
            load_hi  = 1'b1;
            font_nxt = mode_bit;
          end else begin
            load_lo   = 1'b1;
            state_nxt = mode_bit ? ST_STREAM : ST_LO;
          end
        end
        ST_LO: begin
          do_write  = 1'b1;
          state_nxt = ST_AFTER;
        end
        ST_AFTER: begin
          if (is_hi) begin
            load_hi   = 1'b1;
            font_nxt  = mode_bit;
            state_nxt = ST_HI;
          end else if (!mode_bit) begin
            load_lo   = 1'b1;
            state_nxt = ST_LO;
          end
        end
        ST_STREAM: begin
          do_write = 1'b1;
          do_inc   = 1'b1;
        end
        default: state_nxt = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (font_q) data_sel = BYTE_W'(rx_byte[FONT_W-1:0]);
    else        data_sel = rx_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      font_q  <= 1'b0;
      wr_en   <= 1'b0;
      wr_tgt  <= TGT_NONE;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      state  <= state_nxt;
      font_q <= font_nxt;
      wr_en  <= do_write && (map_tgt != TGT_NONE);
      if (do_write) begin
        wr_tgt  <= map_tgt;
        wr_addr <= map_addr;
        wr_data <= data_sel;
      end
    end
  end
endmodule

// File: rtl/atwd_checker.sv
`timescale 1ns/1ps
module atwd_checker #(
  parameter int BYTE_W    = 8,
  parameter int HI_W      = 4,
  parameter int LO_W      = 5,
  parameter int FONT_W    = 5,
  parameter int CHAR_ROWS = 10,
  parameter int CHAR_COLS = 24,
  parameter int RCTL_COL  = 30,
  parameter int CTRL_ROW  = 10,
  parameter int CTRL_COLS = 13,
  localparam int ADDR_W   = HI_W + LO_W
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_valid,
  input logic              txn_stop,
  input logic              wr_en,
  input logic [1:0]        wr_tgt,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data
);
  logic [HI_W-1:0] a_row;
  logic [LO_W-1:0] a_col;
  assign a_row = wr_addr[ADDR_W-1:LO_W];
  assign a_col = wr_addr[LO_W-1:0];

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !wr_en);

  assert_write_follows_byte_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(byte_valid) && !$past(txn_stop)));

  assert_font_data_narrow_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_tgt == 2'd2) |-> ((wr_data >> FONT_W) == '0));

  assert_char_window_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_tgt == 2'd0) |-> (a_row < HI_W'(CHAR_ROWS) && a_col < LO_W'(CHAR_COLS)));

  assert_ctrl_window_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_tgt == 2'd1) |->
      ((a_row < HI_W'(CHAR_ROWS) && a_col >= LO_W'(RCTL_COL)) ||
       (a_row == HI_W'(CTRL_ROW) && a_col < LO_W'(CTRL_COLS))));

  assert_known_target_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_tgt != 2'd3));

  assert_stop_drops_byte_R10: assert property (@(posedge clk) disable iff (rst)
    $past(txn_stop) |-> !wr_en);
endmodule

bind addr_tag_write_decoder atwd_checker #(
  .BYTE_W(BYTE_W), .HI_W(HI_W), .LO_W(LO_W), .FONT_W(FONT_W),
  .CHAR_ROWS(CHAR_ROWS), .CHAR_COLS(CHAR_COLS), .RCTL_COL(RCTL_COL),
  .CTRL_ROW(CTRL_ROW), .CTRL_COLS(CTRL_COLS)
) u_atwd_checker (
  .clk       (clk),
  .rst       (rst),
  .byte_valid(byte_valid),
  .txn_stop  (txn_stop),
  .wr_en     (wr_en),
  .wr_tgt    (wr_tgt),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data)
);

// File: tb/test_addr_tag_write_decoder.sv
`timescale 1ns/1ps
module test_addr_tag_write_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       txn_start = 1'b0;
  logic       txn_stop = 1'b0;
  logic       wr_en;
  logic [1:0] wr_tgt;
  logic [8:0] wr_addr;
  logic [7:0] wr_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  addr_tag_write_decoder i_addr_tag_write_decoder (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .rx_byte(rx_byte),
    .txn_start(txn_start), .txn_stop(txn_stop),
    .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Vector: [34:31] req, [30] start, [29] stop, [28] valid, [27:20] byte,
  //         [19] exp_en, [18:17] exp_tgt, [16:8] exp_addr, [7:0] exp_data
  function automatic logic [34:0] mk(int rq, bit st, bit sp, bit v, logic [7:0] b,
                                     bit en, int tg, int ad, logic [7:0] da);
    return {4'(rq), st, sp, v, b, en, 2'(tg), 9'(ad), da};
  endfunction

  localparam int NV = 52;
  localparam logic [34:0] VEC [NV] = '{
    mk(12,0,0,1,8'h07, 0,0,  0,8'h00), // R12 low byte while waiting
    mk( 3,0,0,1,8'h82, 0,0,  0,8'h00), // R3 row 2
    mk( 3,0,0,1,8'h05, 0,0,  0,8'h00), // R3 col 5
    mk( 3,0,0,1,8'hAB, 1,0, 69,8'hAB), // R3 write
    mk( 4,0,0,1,8'h07, 0,0,  0,8'h00), // R4 col only
    mk( 4,0,0,1,8'hC3, 1,0, 71,8'hC3), // R4 same row
    mk( 8,0,0,1,8'h8A, 0,0,  0,8'h00), // R8 new row 10
    mk( 8,0,0,1,8'h0C, 0,0,  0,8'h00),
    mk( 7,0,0,1,8'h11, 1,1,332,8'h11), // R7 frame reg
    mk( 7,0,0,1,8'h0D, 0,0,  0,8'h00), // R7 col 13
    mk( 7,0,0,1,8'h22, 0,0,  0,8'h00), // R7 unmapped dropped
    mk( 7,0,0,1,8'h83, 0,0,  0,8'h00),
    mk( 7,0,0,1,8'h1E, 0,0,  0,8'h00),
    mk( 7,0,0,1,8'h44, 1,1,126,8'h44), // R7 row ctrl col 30
    mk( 9,0,0,1,8'h45, 0,0,  0,8'h00), // R9 stream tag after data ignored
    mk( 9,0,0,1,8'h1F, 0,0,  0,8'h00),
    mk( 9,0,0,1,8'h55, 1,1,127,8'h55), // R9 still address-driven
    mk( 8,0,0,1,8'h84, 0,0,  0,8'h00), // R8 b->a
    mk( 8,0,0,1,8'h00, 0,0,  0,8'h00),
    mk( 8,0,0,1,8'h5A, 1,0,128,8'h5A),
    mk( 5,0,0,1,8'h81, 0,0,  0,8'h00), // R5 row 1
    mk( 5,0,0,1,8'h5E, 0,0,  0,8'h00), // R5 stream from col 30
    mk( 5,0,0,1,8'h01, 1,1, 62,8'h01),
    mk( 5,0,0,1,8'h82, 1,1, 63,8'h82), // R5 tag bits are data
    mk( 5,0,0,1,8'h03, 1,0, 64,8'h03), // R5 wrap to row 2 col 0
    mk( 5,0,0,1,8'h97, 1,0, 65,8'h97),
    mk(10,0,1,0,8'h00, 0,0,  0,8'h00), // R10 stop
    mk(10,0,0,1,8'h33, 0,0,  0,8'h00), // R10 no stream after stop
    mk( 6,1,0,0,8'h00, 0,0,  0,8'h00), // R6 start
    mk( 6,0,0,1,8'hC5, 0,0,  0,8'h00), // R6 seg 5
    mk( 6,0,0,1,8'h03, 0,0,  0,8'h00), // R6 line 3
    mk( 6,0,0,1,8'hFF, 1,2, 83,8'h1F), // R6 5-bit data
    mk( 6,0,0,1,8'hC2, 0,0,  0,8'h00), // R6 seg 2
    mk( 6,0,0,1,8'h4F, 0,0,  0,8'h00), // R6 stream line 15
    mk( 6,0,0,1,8'h0A, 1,2, 47,8'h0A),
    mk( 6,0,0,1,8'hEE, 1,2, 48,8'h0E), // R6 wrap to seg 3 line 0
    mk( 7,1,0,0,8'h00, 0,0,  0,8'h00), // R7 start
    mk( 7,0,0,1,8'h80, 0,0,  0,8'h00),
    mk( 7,0,0,1,8'h57, 0,0,  0,8'h00), // R7 stream col 23
    mk( 7,0,0,1,8'h10, 1,0, 23,8'h10),
    mk( 7,0,0,1,8'h20, 0,0,  0,8'h00), // R7 col 24 dropped
    mk( 7,0,0,1,8'h21, 0,0,  0,8'h00), // R7 col 25 dropped
    mk(11,1,0,1,8'h84, 0,0,  0,8'h00), // R11 start + row 4
    mk(11,0,0,1,8'h01, 0,0,  0,8'h00),
    mk(11,0,0,1,8'h99, 1,0,129,8'h99), // R11 new location
    mk(10,0,0,1,8'h81, 0,0,  0,8'h00), // R10 row 1
    mk(10,0,0,1,8'h40, 0,0,  0,8'h00), // R10 stream col 0
    mk(10,0,0,1,8'h12, 1,0, 32,8'h12),
    mk(10,0,1,1,8'h77, 0,0,  0,8'h00), // R10 stop + byte dropped
    mk(10,0,0,1,8'h66, 0,0,  0,8'h00), // R10 no write after
    mk( 2,0,0,0,8'h00, 0,0,  0,8'h00), // R2 idle
    mk(12,0,0,1,8'h3C, 0,0,  0,8'h00)  // R12 ignored
  };

  task automatic check(int rq, bit en, int tg, int ad, logic [7:0] da);
    n_run++;
    if (wr_en !== en) begin
      n_fail++;
      $display("FAIL R%0d wr_en actual %0b expected %0b", rq, wr_en, en);
    end else if (en && (wr_tgt !== 2'(tg) || wr_addr !== 9'(ad) || wr_data !== da)) begin
      n_fail++;
      $display("FAIL R%0d tgt/addr/data actual %0d/%0d/%h expected %0d/%0d/%h",
               rq, wr_tgt, wr_addr, wr_data, tg, ad, da);
    end
  endtask

  task automatic drive(bit st, bit sp, bit v, logic [7:0] b);
    txn_start  = st;
    txn_stop   = sp;
    byte_valid = v;
    rx_byte    = b;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 0, 0, 0, 8'h00);            // R1 reset state
    rst = 1'b0;
    drive(1, 0, 0, 8'h00);
    // R2: each vector is sampled one cycle after its byte is presented
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][30], VEC[i][29], VEC[i][28], VEC[i][27:20]);
      check(int'(VEC[i][34:31]), VEC[i][19], int'(VEC[i][18:17]),
            int'(VEC[i][16:8]), VEC[i][7:0]);
    end
    // R2: strobe lasts one cycle
    drive(1, 0, 1, 8'h85);
    drive(0, 0, 1, 8'h02);
    drive(0, 0, 1, 8'h6D);
    check(2, 1, 0, 162, 8'h6D);
    drive(0, 0, 0, 8'h00);
    check(2, 0, 0, 0, 8'h00);
    // R1: reset mid-stream returns to waiting for an address
    drive(1, 0, 1, 8'h80);
    drive(0, 0, 1, 8'h40);
    drive(0, 0, 1, 8'h01);
    check(1, 1, 0, 0, 8'h01);
    rst = 1'b1;
    drive(0, 0, 0, 8'h00);
    check(1, 0, 0, 0, 8'h00);
    rst = 1'b0;
    drive(0, 0, 1, 8'h21);
    check(1, 0, 0, 0, 8'h00);
    drive(0, 0, 0, 8'h00);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule